// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block sits between program memory and the execute stage of a small core whose instructions are 16 bits wide. A few instructions take two program words: a lead word that carries the opcode, and a trailing word that begins with a reserved all-ones 4-bit prefix and carries 12 bits of operand data. The sequencer holds a lead word until its trailing word arrives. It then hands both to the execute stage as one decoded instruction, with the trailing payload on a separate operand bus.

A skip request from the previously executed instruction throws away the word being fetched. If that word was a lead word, its trailing word then arrives with nothing held. Because the trailing word identifies itself by its prefix, the sequencer issues it as a no-operation. A stall input freezes sequencing for a cycle. Outputs are registered and appear one clock after the word that completes an instruction is accepted.

Top module: `ftw_seq`

## Requirements
- R1: After reset is released, valid_o, nop_o, opcode_o and operand_o are all zero.
- R2: A word accepted with nothing held that is not a lead word and does not start with 1111 is issued on the next cycle: valid_o=1, opcode_o=the word, operand_o=0, nop_o=0.
- R3: The lead words are 1100xxxx_xxxxxxxx (file-to-file move), 1110110x_xxxxxxxx (call), 11101111_xxxxxxxx (goto) and 11101110_00xxxxxx (file-select load). An accepted, unskipped lead word issues nothing on the next cycle. When the following word is accepted, the next cycle shows valid_o=1, nop_o=0, opcode_o=the lead word and operand_o=bits 11:0 of the following word.
- R4: A word whose bits 15:12 are 1111, accepted with nothing held and without skip, is issued as a NOP: valid_o=1, nop_o=1, opcode_o=0, operand_o=0.
- R5: skip_i, when a word is accepted with nothing held, discards that word: valid_o is 0 on the next cycle and nothing is held afterwards.
- R6: When a skip discards a lead word, the trailing word that follows is issued as a NOP on the cycle after it is accepted.
- R7: skip_i has no effect while a lead word is held; the pair is issued as in R3.
- R8: While stall_i is 1 the word on word_i is not accepted, valid_o is 0 on the next cycle, and a held lead word is kept.
- R9: nop_o is never 1 while valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | 16 | Fetched program word |
| skip_i | input | 1 | Discard the word fetched this cycle |
| stall_i | input | 1 | Do not accept a word this cycle |
| valid_o | output | 1 | Decoded instruction valid (one-cycle pulse per instruction) |
| opcode_o | output | 16 | Single word or lead word of the instruction |
| operand_o | output | 12 | Payload of the trailing word, zero otherwise |
| nop_o | output | 1 | Issued instruction is an orphaned trailing word, run as NOP |

## Verification
The bench runs a file-to-file move with and without a preceding skip. The unskipped move must deliver its destination payload together with the lead word. The skipped move must produce exactly one NOP, and a design that treated the orphan as a single-word instruction would issue its raw bits with nop_o low. Skip and stall are also asserted while a lead word is held. A design that honoured the skip there would lose the payload, and one that advanced under stall would pair the lead word with the wrong operand. A long random mix of all four lead encodings, near-miss encodings, skips and stalls is compared against a behavioural model every cycle.

// File: rtl/ftw_pkg.sv
package ftw_pkg;
  typedef enum logic [1:0] {
    KIND_ONE  = 2'd0,
    KIND_LEAD = 2'd1,
    KIND_TAIL = 2'd2
  } word_kind_e;

  // top 12 bits of a word -> does it open a two-word instruction
  function automatic logic is_lead(input logic [11:0] top);
    logic lead;
    lead = 1'b0;
    if (top[11:8] == 4'hC) lead = 1'b1;               // file move
    if (top[11:5] == 7'b1110110) lead = 1'b1;         // call
    if (top[11:4] == 8'hEF) lead = 1'b1;              // goto
    if (top[11:2] == 10'b1110111000) lead = 1'b1;     // fsr load
    return lead;
  endfunction
endpackage

// File: rtl/ftw_decode.sv
module ftw_decode
  import ftw_pkg::*;
#(
  parameter int unsigned PFX_W = 4
) (
  input  logic [11:0] top_i,
  output word_kind_e  kind_o
);
  localparam logic [PFX_W-1:0] TailPfx = '1;

  always_comb begin
    if (top_i[11 -: PFX_W] == TailPfx) kind_o = KIND_TAIL;
    else if (is_lead(top_i))          kind_o = KIND_LEAD;
    else                              kind_o = KIND_ONE;
  end
endmodule

// File: rtl/ftw_hold.sv
module ftw_hold
  import ftw_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  word_kind_e        kind_i,
  input  logic              skip_i,
  input  logic              stall_i,
  output logic              iss_one_o,
  output logic              iss_pair_o,
  output logic              iss_nop_o,
  output logic [WORD_W-1:0] lead_o
);
  logic              pend_q;
  logic [WORD_W-1:0] lead_q;
  logic              take, fresh, capture;

  always_comb begin
    take       = ~stall_i;
    fresh      = take & ~pend_q & ~skip_i;
    capture    = fresh & (kind_i == KIND_LEAD);
    iss_pair_o = take & pend_q;           // skip ignored while held
    iss_nop_o  = fresh & (kind_i == KIND_TAIL);
    iss_one_o  = fresh & (kind_i == KIND_ONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lead_q <= '0;
    end else if (capture) begin
      pend_q <= 1'b1;
      lead_q <= word_i;
    end else if (iss_pair_o) begin
      pend_q <= 1'b0;
    end
  end

  assign lead_o = lead_q;
endmodule

// File: rtl/ftw_out.sv
module ftw_out #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAY_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_one_i,
  input  logic              iss_pair_i,
  input  logic              iss_nop_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] lead_i,
  output logic              valid_o,
  output logic              nop_o,
  output logic [WORD_W-1:0] opcode_o,
  output logic [PAY_W-1:0]  operand_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      nop_o     <= 1'b0;
      opcode_o  <= '0;
      operand_o <= '0;
    end else begin
      valid_o <= iss_one_i | iss_pair_i | iss_nop_i;
      nop_o   <= iss_nop_i;
      if (iss_pair_i) begin
        opcode_o  <= lead_i;
        operand_o <= word_i[PAY_W-1:0];
      end else if (iss_one_i) begin
        opcode_o  <= word_i;
        operand_o <= '0;
      end else if (iss_nop_i) begin
        opcode_o  <= '0;
        operand_o <= '0;
      end
    end
  end
endmodule

// File: rtl/ftw_seq.sv
module ftw_seq
  import ftw_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAY_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              skip_i,
  input  logic              stall_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] opcode_o,
  output logic [PAY_W-1:0]  operand_o,
  output logic              nop_o
);
  localparam int unsigned PFX_W = WORD_W - PAY_W;

  word_kind_e        kind;
  logic              iss_one, iss_pair, iss_nop;
  logic [WORD_W-1:0] lead;

  ftw_decode #(.PFX_W(PFX_W)) u_dec (
    .top_i  (word_i[WORD_W-1 -: 12]),
    .kind_o (kind)
  );

  ftw_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word_i),
    .kind_i     (kind),
    .skip_i     (skip_i),
    .stall_i    (stall_i),
    .iss_one_o  (iss_one),
    .iss_pair_o (iss_pair),
    .iss_nop_o  (iss_nop),
    .lead_o     (lead)
  );

  ftw_out #(.WORD_W(WORD_W), .PAY_W(PAY_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iss_one_i  (iss_one),
    .iss_pair_i (iss_pair),
    .iss_nop_i  (iss_nop),
    .word_i     (word_i),
    .lead_i     (lead),
    .valid_o    (valid_o),
    .nop_o      (nop_o),
    .opcode_o   (opcode_o),
    .operand_o  (operand_o)
  );
endmodule

// File: rtl/ftw_seq_chk.sv
module ftw_seq_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAY_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] word_i,
  input logic              skip_i,
  input logic              stall_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] opcode_o,
  input logic [PAY_W-1:0]  operand_o,
  input logic              nop_o
);
  // independent shadow of "lead word held"
  logic held;
  logic acc_free, is_tail, is_lead_w;

  assign acc_free  = ~stall_i & ~held;
  assign is_tail   = &word_i[WORD_W-1 -: 4];
  assign is_lead_w = ~is_tail & ftw_pkg::is_lead(word_i[WORD_W-1 -: 12]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held <= 1'b0;
    else if (!stall_i) held <= held ? 1'b0 : (~skip_i & is_lead_w);
  end

  AST_NOP_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_o |-> valid_o); // R9
  AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !valid_o); // R8
  AST_SKIP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_free && skip_i) |=> !valid_o); // R5
  AST_LEAD_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_free && !skip_i && is_lead_w) |=> !valid_o); // R3
  AST_PAIR_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && held) |=> (valid_o && !nop_o && operand_o == $past(word_i[PAY_W-1:0]))); // R7
  AST_ORPHAN_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_free && !skip_i && is_tail) |=> (valid_o && nop_o)); // R4
  AST_SINGLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_free && !skip_i && !is_tail && !is_lead_w) |=> (valid_o && opcode_o == $past(word_i))); // R2
endmodule

bind ftw_seq ftw_seq_chk #(.WORD_W(WORD_W), .PAY_W(PAY_W)) u_chk (.*);

// File: tb/ftw_seq_test.sv
module ftw_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word = '0;
  logic        skip = 1'b0;
  logic        stall = 1'b0;
  logic        valid, nop;
  logic [15:0] opcode;
  logic [11:0] operand;

  int n_cmp = 0;
  int n_bad = 0;

  // model state
  bit          m_held = 0;
  logic [15:0] m_lead = '0;
  bit          m_skipped_lead = 0;
  bit          e_valid, e_nop;
  logic [15:0] e_op;
  logic [11:0] e_opr;
  string       e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  ftw_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .skip_i(skip), .stall_i(stall),
    .valid_o(valid), .opcode_o(opcode), .operand_o(operand), .nop_o(nop)
  );

  function automatic bit lead_word(input logic [15:0] w);
    case (w[15:12])
      4'hC: return 1;
      4'hE: return (w[11:9] == 3'b110) || (w[11:8] == 4'hF) ||
                   (w[11:8] == 4'hE && w[7:6] == 2'b00);
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    n_cmp++;
    if (valid !== e_valid || nop !== e_nop ||
        (e_valid && (opcode !== e_op || operand !== e_opr))) begin
      n_bad++;
      $display("FAIL %s: got v=%0b n=%0b op=%h opr=%h exp v=%0b n=%0b op=%h opr=%h",
               e_tag, valid, nop, opcode, operand, e_valid, e_nop, e_op, e_opr);
    end
  endtask

  task automatic step(input logic [15:0] w, input bit sk, input bit st);
    bit was_skip_lead;
    word = w; skip = sk; stall = st;
    was_skip_lead = m_skipped_lead;
    e_valid = 0; e_nop = 0; e_op = 'x; e_opr = 'x;
    if (st) begin
      e_tag = "R8";
    end else begin
      m_skipped_lead = 0;
      if (m_held) begin
        e_valid = 1; e_op = m_lead; e_opr = w[11:0]; m_held = 0;
        e_tag = sk ? "R7" : "R3";
      end else if (sk) begin
        e_tag = "R5";
        m_skipped_lead = lead_word(w) && w[15:12] != 4'hF;
      end else if (w[15:12] == 4'hF) begin
        e_valid = 1; e_nop = 1; e_op = 0; e_opr = 0;
        e_tag = was_skip_lead ? "R6" : "R4";
      end else if (lead_word(w)) begin
        m_held = 1; m_lead = w; e_tag = "R3";
      end else begin
        e_valid = 1; e_op = w; e_opr = 0; e_tag = "R2";
      end
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 2);
    // R1: reset state
    e_valid = 0; e_nop = 0; e_op = 0; e_opr = 0; e_tag = "R1";
    compare();
    n_cmp++;
    if (opcode !== 0 || operand !== 0) begin
      n_bad++;
      $display("FAIL R1: got op=%h opr=%h exp 0 0", opcode, operand);
    end
    rst_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);

    // no skip: test-skip then file move with payload used (R2, R3)
    step(16'h6600, 0, 0);
    step(16'hC123, 0, 0);
    step(16'hF456, 0, 0);
    step(16'h2400, 0, 0);
    // skip lands on the move: one word discarded, tail as NOP (R5, R6)
    step(16'h6600, 0, 0);
    step(16'hC123, 1, 0);
    step(16'hF456, 0, 0);
    step(16'h2400, 0, 0);
    // skip on a single word (R5)
    step(16'h2401, 1, 0);
    step(16'h0F0F, 0, 0);
    // skip ignored while held (R7)
    step(16'hEC12, 0, 0);
    step(16'hF9AB, 1, 0);
    // stall while held keeps lead (R8)
    step(16'hEF34, 0, 0);
    step(16'h1111, 0, 1);
    step(16'hF777, 1, 1);
    step(16'hF0CD, 0, 0);
    // file-select load and near misses
    step(16'hEE2A, 0, 0);
    step(16'hF001, 0, 0);
    step(16'hEE4A, 0, 0);
    step(16'hEA00, 0, 0);
    // orphan tail with nothing before (R4), and R9 via nop/valid pairing
    step(16'hFFFF, 0, 0);
    step(16'hF000, 0, 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      int sel;
      sel = $urandom_range(0, 7);
      w = 16'($urandom);
      case (sel)
        0: w[15:12] = 4'hC;
        1: w[15:8]  = 8'hEC | 8'($urandom_range(0, 3));
        2: w[15:6]  = 10'b1110111000;
        3, 4: w[15:12] = 4'hF;
        default: ;
      endcase
      step(w, $urandom_range(0, 4) == 0, $urandom_range(0, 5) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule